// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner and Lock Detector

This block sits behind a serial receiver that delivers one recovered bit per cycle of a bit-rate clock. The line carries 20-bit frames. Each frame is a 1 start bit, 18 payload bits and a 0 stop bit, so the 0-to-1 step from one frame's stop bit to the next frame's start bit acts as an embedded clock edge. The aligner does not know where frames begin. It watches all 20 possible bit offsets at the same time and counts, for each offset, how many frames in a row showed that edge with a valid start/stop pair.

Lock is granted to an offset only when that offset is the single clear winner. A repeating pattern that produces the same edge at several offsets is held off until the pattern changes. Once locked, the block emits one parallel word per frame with a one-cycle strobe. It tracks the framing bits and returns to the search on its own when two frames in a row lose them. The lock indicator is active low. A power-down input clears everything and restarts the search, and an output-enable input gates only the data outputs.

Top module: `fa_frame_aligner`

## Requirements
- R1: The line order within a frame is start bit (1), payload bit 0 through payload bit 17, then stop bit (0). Bit i of `word_o` equals the (i+1)-th line bit after the start bit.
- R2: `lock_no` is 1 while unlocked and 0 while locked. It falls on the same clock edge that raises `word_vld_o` for the first delivered word.
- R3: While `lock_no` is 1, `word_o` is all ones.
- R4: `word_vld_o` is high only while locked, for one cycle per frame, and two strobes are never closer than 20 cycles apart.
- R5: An offset qualifies after 4 consecutive frames that each show a 0 bit, then a 1 start bit, then a 0 stop bit 19 bits later. With the payload 0x001FF (nine ones, then nine zeros), lock and the first strobe come exactly at the stop bit of the 4th frame.
- R6: Lock is refused while any other offset has at least 3 consecutive qualifying frames. The alternating payload 0x2AAAA never locks. Once the stream changes to an unambiguous pattern, lock follows within a few frames.
- R7: While locked, a single frame whose start or stop bit is wrong produces no strobe and keeps `lock_no` at 0. The next good frame is delivered normally.
- R8: Two consecutive bad frames raise `lock_no` at the stop bit of the second one. The search then restarts with all counts at zero, so relock needs 4 fresh qualifying frames.
- R9: While `pwr_ni` is 0, `oe_o` is 0, `lock_no` is 1 from the next edge and no strobe is given. After `pwr_ni` returns to 1, the search starts from an empty history.
- R10: While `oe_i` is 0, `oe_o` is 0, but lock, strobes and words continue unchanged.
- R11: On random payloads, the block locks to the true frame offset and every delivered word equals the payload sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock, one line bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Recovered serial bit |
| pwr_ni | input | 1 | Power-down, active low; clears lock and history |
| oe_i | input | 1 | Data output enable request |
| word_o | output | 18 | Recovered payload word, all ones while unlocked |
| word_vld_o | output | 1 | One-cycle strobe per delivered word |
| lock_no | output | 1 | Lock indicator, 0 when locked |
| oe_o | output | 1 | Enable for the data output drivers |

## Verification
The bench aims at the edges of the lock decision. It checks that the sync payload locks at exactly the fourth frame rather than the third or fifth, which catches an off-by-one in the qualify count. It checks that the alternating payload never locks, which a design that grants lock to the first offset to qualify would get wrong. It also checks that the ambiguity clears once the stream changes. For loss of lock, a single bad stop bit must leave lock in place while two in a row must drop it. A design that also tested the previous frame's stop bit while tracking would drop lock after one bad frame. After the drop, relock must take a full four fresh frames, which exposes stale counts left over from before. Payload bit order is checked with one-hot words and random words.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic {
    TRK_HUNT = 1'b0,
    TRK_LOCK = 1'b1
  } trk_state_e;
endpackage

// File: rtl/fa_window.sv
// Keeps the last FRAME_W bits; win_o adds the current bit as LSB.
module fa_window #(
  parameter int FRAME_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               bit_i,
  output logic [FRAME_W:0]   win_o
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (clr_i) sr_q <= '0;
    else            sr_q <= {sr_q[FRAME_W-2:0], bit_i};
  end

  assign win_o = {sr_q, bit_i};
endmodule

// File: rtl/fa_phase_hunt.sv
// One consecutive-hit counter per frame offset; grants acquisition to a sole contender.
module fa_phase_hunt #(
  parameter int FRAME_W     = 20,
  parameter int LOCK_FRAMES = 4,
  localparam int PH_W       = $clog2(FRAME_W),
  localparam int CNT_W      = $clog2(LOCK_FRAMES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic            edge_i,
  output logic            acquire_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LOCK_FRAMES);
  localparam logic [CNT_W-1:0] CNT_CON = CNT_W'(LOCK_FRAMES - 1);

  logic [FRAME_W-1:0] sel;
  logic [FRAME_W-1:0] contend;

  for (genvar q = 0; q < FRAME_W; q++) begin : g_ph
    logic [CNT_W-1:0] cnt_q;

    assign sel[q]     = (ph_i == PH_W'(q));
    assign contend[q] = (cnt_q >= CNT_CON);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (sel[q]) begin
        if (!edge_i)               cnt_q <= '0;
        else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // current offset reaches saturation now, and no other offset is close behind
  assign acquire_o = edge_i && !clr_i && |(sel & contend) && !(|(contend & ~sel));
endmodule

// File: rtl/fa_lock_track.sv
// Holds the locked offset, extracts payload words and counts missing clock edges.
module fa_lock_track #(
  parameter int DATA_W     = 18,
  parameter int MISS_LIMIT = 2,
  localparam int FRAME_W   = DATA_W + 2,
  localparam int PH_W      = $clog2(FRAME_W),
  localparam int MISS_W    = $clog2(MISS_LIMIT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwr_ni,
  input  logic               acquire_i,
  input  logic [PH_W-1:0]    ph_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               locked_o,
  output logic [DATA_W-1:0]  word_o,
  output logic               word_vld_o
);
  import fa_pkg::*;

  trk_state_e        st_q;
  logic [PH_W-1:0]   lph_q;
  logic [MISS_W-1:0] miss_q;
  logic [DATA_W-1:0] word_q;
  logic              vld_q;
  logic [DATA_W-1:0] pay;
  logic              frame_ok;

  // frame_i[FRAME_W-1] is the start bit, frame_i[0] the stop bit
  assign frame_ok = frame_i[FRAME_W-1] & ~frame_i[0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_pay
    assign pay[i] = frame_i[FRAME_W-2-i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TRK_HUNT;
      lph_q  <= '0;
      miss_q <= '0;
      word_q <= '1;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (!pwr_ni) begin
        st_q   <= TRK_HUNT;
        miss_q <= '0;
        word_q <= '1;
      end else if (st_q == TRK_HUNT) begin
        if (acquire_i) begin
          st_q   <= TRK_LOCK;
          lph_q  <= ph_i;
          miss_q <= '0;
          word_q <= pay;
          vld_q  <= 1'b1;
        end
      end else if (ph_i == lph_q) begin
        if (frame_ok) begin
          miss_q <= '0;
          word_q <= pay;
          vld_q  <= 1'b1;
        end else if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
          st_q   <= TRK_HUNT;
          miss_q <= '0;
          word_q <= '1;
        end else begin
          miss_q <= miss_q + MISS_W'(1);
        end
      end
    end
  end

  assign locked_o   = (st_q == TRK_LOCK);
  assign word_o     = word_q;
  assign word_vld_o = vld_q;
endmodule

// File: rtl/fa_frame_aligner.sv
module fa_frame_aligner #(
  parameter int DATA_W      = 18,
  parameter int LOCK_FRAMES = 4,
  parameter int MISS_LIMIT  = 2,
  localparam int FRAME_W    = DATA_W + 2,
  localparam int PH_W       = $clog2(FRAME_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              pwr_ni,
  input  logic              oe_i,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              lock_no,
  output logic              oe_o
);
  logic [FRAME_W:0]  win;
  logic [PH_W-1:0]   ph_q;
  logic              edge_hit;
  logic              acquire;
  logic              locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ph_q <= '0;
    else if (ph_q == PH_W'(FRAME_W - 1))     ph_q <= '0;
    else                                     ph_q <= ph_q + PH_W'(1);
  end

  fa_window #(.FRAME_W(FRAME_W)) u_window (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~pwr_ni),
    .bit_i (bit_i),
    .win_o (win)
  );

  // previous stop 0, start 1, own stop 0
  assign edge_hit = ~win[FRAME_W] & win[FRAME_W-1] & ~win[0];

  fa_phase_hunt #(
    .FRAME_W    (FRAME_W),
    .LOCK_FRAMES(LOCK_FRAMES)
  ) u_hunt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (locked | ~pwr_ni),
    .ph_i     (ph_q),
    .edge_i   (edge_hit),
    .acquire_o(acquire)
  );

  fa_lock_track #(
    .DATA_W    (DATA_W),
    .MISS_LIMIT(MISS_LIMIT)
  ) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_ni    (pwr_ni),
    .acquire_i (acquire),
    .ph_i      (ph_q),
    .frame_i   (win[FRAME_W-1:0]),
    .locked_o  (locked),
    .word_o    (word_o),
    .word_vld_o(word_vld_o)
  );

  assign lock_no = ~locked;
  assign oe_o    = pwr_ni & oe_i;
endmodule

// File: rtl/fa_frame_aligner_chk.sv
module fa_frame_aligner_chk #(
  parameter int DATA_W   = 18,
  localparam int FRAME_W = DATA_W + 2,
  localparam int GAP_W   = $clog2(FRAME_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_ni,
  input logic              oe_i,
  input logic [DATA_W-1:0] word_o,
  input logic              word_vld_o,
  input logic              lock_no,
  input logic              oe_o
);
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         gap_q <= GAP_W'(FRAME_W);
    else if (word_vld_o)                 gap_q <= GAP_W'(1);
    else if (gap_q < GAP_W'(FRAME_W))    gap_q <= gap_q + GAP_W'(1);
  end

  p_fall_with_vld_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_no) |-> word_vld_o);

  p_ones_unlocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_no |-> (word_o == '1));

  p_vld_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> !lock_no);

  p_vld_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> (gap_q >= GAP_W'(FRAME_W)));

  p_pd_unlock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ni |=> (lock_no && !word_vld_o));

  p_oe_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !oe_o);
endmodule

bind fa_frame_aligner fa_frame_aligner_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_ni    (pwr_ni),
  .oe_i      (oe_i),
  .word_o    (word_o),
  .word_vld_o(word_vld_o),
  .lock_no   (lock_no),
  .oe_o      (oe_o)
);

// File: tb/fa_frame_aligner_bench.sv
module fa_frame_aligner_bench;
  localparam int DW = 18;
  localparam logic [DW-1:0] SYNC = 18'h001FF;
  localparam logic [DW-1:0] ALT  = 18'h2AAAA;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0;
  logic pwr_ni = 1'b1;
  logic oe_i = 1'b1;
  logic [DW-1:0] word_o;
  logic word_vld_o, lock_no, oe_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic s_vld, s_lock, s_oe;
  logic [DW-1:0] s_word;

  always #10 clk = ~clk;

  fa_frame_aligner u_fa_frame_aligner (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .pwr_ni(pwr_ni), .oe_i(oe_i),
    .word_o(word_o), .word_vld_o(word_vld_o), .lock_no(lock_no), .oe_o(oe_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic b);
    @(negedge clk);
    bit_i = b;
    @(posedge clk);
    #2;
    s_vld  = word_vld_o;
    s_lock = lock_no;
    s_oe   = oe_o;
    s_word = word_o;
  endtask

  task automatic send_frame(input logic [DW-1:0] w, input logic bad_stop);
    step(1'b1);
    for (int i = 0; i < DW; i++) step(w[i]);
    step(bad_stop);
  endtask

  task automatic pd_pulse();
    pwr_ni = 1'b0;
    for (int i = 0; i < 5; i++) step(1'b0);
    pwr_ni = 1'b1;
    step(1'b0);
    step(1'b0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] w;
    int got;
    int at;
    logic [DW-1:0] lw;
    void'($urandom(32'd2024));

    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0);
    // R3 R2 reset state
    chk(s_lock == 1'b1, "R2 reset lock", s_lock, 1);
    chk(s_word == '1, "R3 reset word", s_word, 18'h3FFFF);
    chk(s_vld == 1'b0, "R4 reset strobe", s_vld, 0);
    chk(s_oe == 1'b1, "R10 reset oe", s_oe, 1);

    // R5 sync payload locks on the 4th frame
    for (int f = 0; f < 4; f++) begin
      send_frame(SYNC, 1'b0);
      if (f < 3) chk(s_lock == 1'b1 && s_vld == 1'b0, "R5 early lock", s_lock, 1);
      else begin
        chk(s_lock == 1'b0, "R5 lock at 4th frame", s_lock, 0);
        chk(s_vld == 1'b1, "R2 strobe with lock", s_vld, 1);
        chk(s_word == SYNC, "R5 sync word", s_word, SYNC);
      end
    end

    // R1 bit order
    send_frame(18'h00001, 1'b0);
    chk(s_vld && s_word == 18'h00001, "R1 bit0 first", s_word, 18'h00001);
    send_frame(18'h20000, 1'b0);
    chk(s_vld && s_word == 18'h20000, "R1 bit17 last", s_word, 18'h20000);
    for (int k = 0; k < 16; k++) begin
      w = DW'($urandom());
      send_frame(w, 1'b0);
      chk(s_vld && s_word == w, "R1 random word", s_word, w);
    end

    // R7 single bad stop
    w = DW'($urandom());
    send_frame(w, 1'b1);
    chk(s_vld == 1'b0, "R7 no strobe on bad frame", s_vld, 0);
    chk(s_lock == 1'b0, "R7 lock kept", s_lock, 0);
    w = DW'($urandom());
    send_frame(w, 1'b0);
    chk(s_vld && s_word == w, "R7 next word", s_word, w);

    // R8 two bad stops drop lock, relock after 4 fresh frames
    send_frame(SYNC, 1'b1);
    chk(s_lock == 1'b0, "R8 lock after first miss", s_lock, 0);
    send_frame(SYNC, 1'b1);
    chk(s_lock == 1'b1, "R8 unlock after second miss", s_lock, 1);
    chk(s_word == '1, "R3 ones after unlock", s_word, 18'h3FFFF);
    for (int f = 0; f < 5; f++) begin
      send_frame(SYNC, 1'b0);
      if (f < 4) chk(s_lock == 1'b1, "R8 no early relock", s_lock, 1);
      else chk(s_lock == 1'b0 && s_vld && s_word == SYNC, "R8 relock", s_lock, 0);
    end

    // R10 output enable low
    oe_i = 1'b0;
    for (int f = 0; f < 2; f++) begin
      w = DW'($urandom());
      send_frame(w, 1'b0);
      chk(s_oe == 1'b0, "R10 oe_o low", s_oe, 0);
      chk(s_lock == 1'b0 && s_vld && s_word == w, "R10 data continues", s_word, w);
    end
    oe_i = 1'b1;
    step(1'b0);
    chk(s_oe == 1'b1, "R10 oe_o back", s_oe, 1);
    for (int i = 0; i < DW + 1; i++) step(1'b0);

    // R9 power-down
    pwr_ni = 1'b0;
    step(1'b0);
    step(1'b0);
    chk(s_oe == 1'b0, "R9 oe_o off", s_oe, 0);
    chk(s_lock == 1'b1, "R9 lock lost", s_lock, 1);
    chk(s_word == '1, "R9 word ones", s_word, 18'h3FFFF);
    pwr_ni = 1'b1;
    step(1'b0);
    step(1'b0);
    for (int f = 0; f < 4; f++) begin
      send_frame(SYNC, 1'b0);
      if (f < 3) chk(s_lock == 1'b1, "R9 search restarted", s_lock, 1);
      else chk(s_lock == 1'b0 && s_word == SYNC, "R9 relock", s_lock, 0);
    end

    // R6 alternating payload refused, then unambiguous pattern locks
    pd_pulse();
    got = 0;
    for (int f = 0; f < 12; f++) begin
      send_frame(ALT, 1'b0);
      if (!s_lock) got++;
    end
    chk(got == 0, "R6 alternating refused", got, 0);
    at = -1;
    lw = '0;
    for (int f = 0; f < 6; f++) begin
      send_frame(SYNC, 1'b0);
      if (at < 0 && !s_lock) begin
        at = f;
        lw = s_word;
      end
    end
    chk(at >= 0, "R6 lock after change", at, 0);
    chk(lw == SYNC, "R6 word at lock", lw, SYNC);

    // R11 random data lock
    pd_pulse();
    at = -1;
    for (int f = 0; f < 14; f++) begin
      w = DW'($urandom());
      send_frame(w, 1'b0);
      if (!s_lock) begin
        if (at < 0) at = f;
        chk(s_vld && s_word == w, "R11 locked word", s_word, w);
      end
    end
    chk(at >= 0, "R11 random lock", at, 0);
    for (int f = 0; f < 8; f++) begin
      w = DW'($urandom());
      send_frame(w, 1'b0);
      chk(!s_lock && s_vld && s_word == w, "R11 tracking", s_word, w);
    end

    done = 1'b1;
    finish_run();
  end
endmodule